// File: doc/BRIEF.md
# Pattern-Match Boolean Interrupt Engine

This block evaluates a configurable sum of products over a set of input channels and turns the result into interrupt lines and an event pulse. It has eight bit slices. Each slice picks one channel and applies one of eight match conditions: a constant, a level, a one-cycle change marker, or an edge that is held until software reprograms the slice.

Runs of consecutive slices are ANDed into product terms. Endpoint marks in the configuration word close each term. A closed term that is true raises the interrupt line of its endpoint slice. The OR of all terms drives a single event pulse.

Software programs the block through a narrow write port with three words: control, source and condition. It can read the live per-slice match state back through the control word. The channels are sampled through a two-stage register chain. The interrupt, event and match outputs are registered, so a channel change is visible on them two clocks after it is presented.

Top module: `pmatch_engine`

## Requirements
- R1: While `rst` is high and after it, all three words reset to zero. During reset, `match_state`, `pm_irq`, `pm_event` and `ctrl_rdata` are zero.
- R2: A write with `wr_sel`=1 loads the source word. Slice i takes its channel number from bits [8+3i+2 : 8+3i].
- R3: A write with `wr_sel`=2 loads the condition word. Slice i takes its condition code from bits [8+3i+2 : 8+3i]. The codes are: 0 always true, 1 held rising edge, 2 held falling edge, 3 held rising-or-falling edge, 4 channel high, 5 channel low, 6 always false, 7 change marker.
- R4: A held edge condition (codes 1 to 3) becomes true in the cycle its edge is seen and stays true until the source or condition word is written. If that write and an edge fall in the same cycle, the edge still counts for that cycle, and the condition is false from the next cycle on.
- R5: Code 7 is true for exactly one cycle after each change of the selected channel, in either direction.
- R6: Bits 0 to 6 of the condition word mark slices 0 to 6 as term endpoints. Slice 7 always ends a term. The term ending at slice n is the AND of the slices after the previous endpoint up to and including n. That term drives `pm_irq[n]`. `pm_irq` bits of slices that are not endpoints stay 0.
- R7: Control word bit 0 (written with `wr_sel`=0) enables pattern-match operation. While it is 0, `pm_irq` and `pm_event` stay 0.
- R8: `pm_event` is high for exactly one cycle when the OR of all terms goes from false to true while control bit 1 is set. With bit 1 clear, no pulse occurs.
- R9: `match_state` gives each slice's current condition value in every mode. `ctrl_rdata` bits 31:24 repeat it, and bits 1:0 show control bits 1:0.
- R10: A change on `chan_in` appears on the outputs two clocks later, and not one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wr_sel | input | 2 | Word select: 0 control, 1 source, 2 condition |
| wr_data | input | 32 | Write data |
| chan_in | input | 8 | Input channels |
| match_state | output | 8 | Per-slice condition value |
| pm_irq | output | 8 | Per-endpoint term interrupts |
| pm_event | output | 1 | One-cycle event pulse |
| ctrl_rdata | output | 32 | Control word readback with match state in bits 31:24 |

## Verification
Two functions can meet in one cycle: a write to the source or condition word, which clears the held edges, and the arrival of a held edge on a channel. The bench raises a channel one cycle before it issues a condition-word write, so that the edge reaches the slice in the cycle the write lands. The bench expects the interrupt to be high for that one cycle and low afterwards. Term evaluation and the event pulse also fall together. A cycle-by-cycle behavioural model judges these interactions on every clock, alongside the directed checks.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic [2:0] {
    C_ONE    = 3'd0,
    C_RISE   = 3'd1,
    C_FALL   = 3'd2,
    C_ANY    = 3'd3,
    C_HIGH   = 3'd4,
    C_LOW    = 3'd5,
    C_ZERO   = 3'd6,
    C_TOGGLE = 3'd7
  } cond_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_COND = 2'd2;

  localparam int FIELD_LSB = 8;
  localparam int COND_W    = 3;
endpackage

// File: rtl/pme_regs.sv
module pme_regs #(
  parameter int NUM_SLICES = 8,
  parameter int SEL_W      = 3,
  parameter int DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          mode_q,
  output logic                          evt_en_q,
  output logic [NUM_SLICES*SEL_W-1:0]   src_q,
  output logic [NUM_SLICES*3-1:0]       cond_q,
  output logic [NUM_SLICES-1:0]         endpt,
  output logic                          edge_clr
);
  import pme_pkg::*;
  localparam int SRC_BITS  = NUM_SLICES * SEL_W;
  localparam int COND_BITS = NUM_SLICES * COND_W;

  logic [NUM_SLICES-2:0] endpt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      evt_en_q <= 1'b0;
      src_q    <= '0;
      cond_q   <= '0;
      endpt_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          mode_q   <= wr_data[0];
          evt_en_q <= wr_data[1];
        end
        SEL_SRC:  src_q <= wr_data[FIELD_LSB +: SRC_BITS];
        SEL_COND: begin
          cond_q  <= wr_data[FIELD_LSB +: COND_BITS];
          endpt_q <= wr_data[NUM_SLICES-2:0];
        end
        default: ;
      endcase
    end
  end

  assign endpt    = {1'b1, endpt_q};
  assign edge_clr = wr_en && (wr_sel == SEL_SRC || wr_sel == SEL_COND);
endmodule

// File: rtl/pme_slice.sv
module pme_slice #(
  parameter int NUM_CHAN = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CHAN-1:0] chan_now,
  input  logic [NUM_CHAN-1:0] chan_prev,
  input  logic [SEL_W-1:0]    sel,
  input  pme_pkg::cond_e      cond,
  input  logic                clr,
  output logic                hit,
  output logic                held_q
);
  import pme_pkg::*;
  logic cur, old, rise, fall, edge_hit;

  assign cur  = chan_now[sel];
  assign old  = chan_prev[sel];
  assign rise = cur & ~old;
  assign fall = ~cur & old;

  always_comb begin
    case (cond)
      C_RISE:  edge_hit = rise;
      C_FALL:  edge_hit = fall;
      C_ANY:   edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) held_q <= 1'b0;
    else if (edge_hit) held_q <= 1'b1;
  end

  always_comb begin
    case (cond)
      C_ONE:    hit = 1'b1;
      C_RISE, C_FALL, C_ANY: hit = held_q | edge_hit;
      C_HIGH:   hit = cur;
      C_LOW:    hit = ~cur;
      C_ZERO:   hit = 1'b0;
      default:  hit = rise | fall;
    endcase
  end
endmodule

// File: rtl/pme_combine.sv
module pme_combine #(
  parameter int NUM_SLICES = 8
) (
  input  logic [NUM_SLICES-1:0] hit,
  input  logic [NUM_SLICES-1:0] endpt,
  output logic [NUM_SLICES-1:0] term
);
  logic acc;
  always_comb begin
    acc  = 1'b1;
    term = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      acc = acc & hit[i];
      if (endpt[i]) begin
        term[i] = acc;
        acc     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmatch_engine.sv
module pmatch_engine #(
  parameter int NUM_SLICES = 8,
  parameter int NUM_CHAN   = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_CHAN-1:0]   chan_in,
  output logic [NUM_SLICES-1:0] match_state,
  output logic [NUM_SLICES-1:0] pm_irq,
  output logic                  pm_event,
  output logic [DATA_W-1:0]     ctrl_rdata
);
  import pme_pkg::*;
  localparam int SEL_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int ZERO_W = DATA_W - NUM_SLICES - 2;

  logic                        mode_q, evt_en_q, edge_clr;
  logic [NUM_SLICES*SEL_W-1:0] src_q;
  logic [NUM_SLICES*3-1:0]     cond_q;
  logic [NUM_SLICES-1:0]       endpt, hit, held, term;
  logic [NUM_CHAN-1:0]         chan_d, chan_dd;
  logic                        any_term, any_q;

  pme_regs #(.NUM_SLICES(NUM_SLICES), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_q(mode_q), .evt_en_q(evt_en_q), .src_q(src_q), .cond_q(cond_q),
    .endpt(endpt), .edge_clr(edge_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_d  <= '0;
      chan_dd <= '0;
    end else begin
      chan_d  <= chan_in;
      chan_dd <= chan_d;
    end
  end

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    pme_slice #(.NUM_CHAN(NUM_CHAN), .SEL_W(SEL_W)) u_slice (
      .clk(clk), .rst(rst), .chan_now(chan_d), .chan_prev(chan_dd),
      .sel(src_q[g*SEL_W +: SEL_W]), .cond(cond_e'(cond_q[g*3 +: 3])),
      .clr(edge_clr), .hit(hit[g]), .held_q(held[g])
    );
  end

  pme_combine #(.NUM_SLICES(NUM_SLICES)) u_comb (
    .hit(hit), .endpt(endpt), .term(term)
  );

  assign any_term = mode_q & (|term);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_state <= '0;
      pm_irq      <= '0;
      pm_event    <= 1'b0;
      any_q       <= 1'b0;
    end else begin
      match_state <= hit;
      pm_irq      <= mode_q ? term : '0;
      pm_event    <= any_term & ~any_q & evt_en_q;
      any_q       <= any_term;
    end
  end

  assign ctrl_rdata = {match_state, {ZERO_W{1'b0}}, evt_en_q, mode_q};
endmodule

// File: rtl/pme_chk.sv
module pme_chk #(
  parameter int NUM_SLICES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [1:0]            wr_sel,
  input logic                  mode_q,
  input logic                  evt_en_q,
  input logic [NUM_SLICES-1:0] endpt,
  input logic [NUM_SLICES-1:0] held,
  input logic [NUM_SLICES-1:0] pm_irq,
  input logic                  pm_event
);
  // R6
  irq_on_endpoint_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_irq & ~$past(endpt)) == '0);

  // R7
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (pm_irq == '0) && !pm_event);

  // R8
  event_single_chk: assert property (@(posedge clk) disable iff (rst)
    pm_event |=> !pm_event);

  // R8
  event_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    pm_event |-> $past(evt_en_q));

  // R4
  held_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2)) |=> (held == '0));
endmodule

bind pmatch_engine pme_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .mode_q(mode_q),
  .evt_en_q(evt_en_q), .endpt(endpt), .held(held), .pm_irq(pm_irq),
  .pm_event(pm_event)
);

// File: tb/pmatch_engine_bench.sv
module pmatch_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [7:0]  chan_in = '0;
  logic [7:0]  match_state, pm_irq;
  logic        pm_event;
  logic [31:0] ctrl_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pmatch_engine u_pmatch_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .chan_in(chan_in), .match_state(match_state), .pm_irq(pm_irq),
    .pm_event(pm_event), .ctrl_rdata(ctrl_rdata)
  );

  // behavioural reference model
  bit [7:0] m_cd, m_cdd, m_held, m_endp, x_match, x_irq;
  int       m_src[8], m_code[8];
  bit       m_mode, m_ev, m_or, x_evt;

  always @(posedge clk) begin
    bit [7:0] hits, terms, nheld;
    bit all_true, orv;
    if (rst) begin
      m_cd = 0; m_cdd = 0; m_held = 0; m_endp = 0;
      m_mode = 0; m_ev = 0; m_or = 0;
      x_match = 0; x_irq = 0; x_evt = 0;
      for (int i = 0; i < 8; i++) begin m_src[i] = 0; m_code[i] = 0; end
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit c, o, r, f, e;
        c = m_cd[m_src[i]]; o = m_cdd[m_src[i]];
        r = c && !o; f = !c && o;
        e = (m_code[i] == 1 && r) || (m_code[i] == 2 && f) || (m_code[i] == 3 && (r || f));
        case (m_code[i])
          0: hits[i] = 1;
          1, 2, 3: hits[i] = m_held[i] || e;
          4: hits[i] = c;
          5: hits[i] = !c;
          6: hits[i] = 0;
          default: hits[i] = r || f;
        endcase
        nheld[i] = m_held[i] || e;
      end
      terms = 0;
      all_true = 1;
      for (int i = 0; i < 8; i++) begin
        all_true = all_true && hits[i];
        if (i == 7 || m_endp[i]) begin terms[i] = all_true; all_true = 1; end
      end
      x_match = hits;
      x_irq   = m_mode ? terms : 8'h00;
      orv     = m_mode && (terms != 0);
      x_evt   = orv && !m_or && m_ev;
      m_or    = orv;
      if (wr_en && (wr_sel == 1 || wr_sel == 2)) nheld = 0;
      m_held = nheld;
      if (wr_en) begin
        if (wr_sel == 0) begin m_mode = wr_data[0]; m_ev = wr_data[1]; end
        if (wr_sel == 1) for (int i = 0; i < 8; i++) m_src[i] = int'(wr_data[8+3*i +: 3]);
        if (wr_sel == 2) begin
          for (int i = 0; i < 8; i++) m_code[i] = int'(wr_data[8+3*i +: 3]);
          m_endp = {1'b0, wr_data[6:0]};
        end
      end
      m_cdd = m_cd;
      m_cd  = chan_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 match_state", {24'h0, match_state}, {24'h0, x_match});
      chk("R6 pm_irq", {24'h0, pm_irq}, {24'h0, x_irq});
      chk("R8 pm_event", {31'h0, pm_event}, {31'h0, x_evt});
      chk("R9 ctrl_rdata", ctrl_rdata, {x_match, 22'h0, m_ev, m_mode});
    end
  end

  function automatic logic [31:0] fld(int slice, int val);
    return 32'(val) << (8 + 3*slice);
  endfunction

  function automatic logic [31:0] all_code(int code);
    logic [31:0] w = '0;
    for (int i = 0; i < 8; i++) w |= fld(i, code);
    return w;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  logic [31:0] ident_src, ident_cond;

  initial begin
    ident_src = '0; ident_cond = '0;
    for (int i = 0; i < 8; i++) begin
      ident_src  |= fld(i, i);
      ident_cond |= fld(i, i);
    end
    step(3);
    // R1 reset state
    chk("R1 irq in reset", {24'h0, pm_irq}, 32'h0);
    chk("R1 event in reset", {31'h0, pm_event}, 32'h0);
    chk("R1 ctrl in reset", ctrl_rdata, 32'h0);
    rst = 1'b0;
    step(2);

    wr(2'd0, 32'h3);
    wr(2'd1, ident_src);
    wr(2'd2, all_code(4) | 32'h7F);
    chan_in = 8'hA5; step(2);
    chk("R2 identity sources", {24'h0, pm_irq}, 32'hA5);
    // R10 latency
    chan_in = 8'h5A; step(1);
    chk("R10 not yet one clock", {24'h0, pm_irq}, 32'hA5);
    step(1);
    chk("R10 two clocks", {24'h0, pm_irq}, 32'h5A);
    // R2 all slices on channel 3
    wr(2'd1, all_code(3));
    chan_in = 8'h08; step(2);
    chk("R2 channel 3 high", {24'h0, pm_irq}, 32'hFF);
    chan_in = 8'hF7; step(2);
    chk("R2 channel 3 low", {24'h0, pm_irq}, 32'h00);

    // R3 encodings
    wr(2'd1, ident_src);
    wr(2'd2, ident_cond | 32'h7F);
    chan_in = 8'h00; step(3);
    chan_in = 8'hFF; step(3);
    chk("R3 code0 true", {31'h0, pm_irq[0]}, 32'h1);
    chk("R3 code6 false", {31'h0, pm_irq[6]}, 32'h0);
    chk("R3 code4 high", {31'h0, pm_irq[4]}, 32'h1);
    chk("R3 code5 low", {31'h0, pm_irq[5]}, 32'h0);
    // R4 held rising edge stays after channel drops
    chan_in = 8'h00; step(3);
    chk("R4 held rise", {31'h0, pm_irq[1]}, 32'h1);
    wr(2'd2, ident_cond | 32'h7F); step(1);
    chk("R4 cleared by write", {31'h0, pm_irq[1]}, 32'h0);
    // R5 change marker on slice 7
    chan_in = 8'h80; step(2);
    chk("R5 marker high", {31'h0, pm_irq[7]}, 32'h1);
    step(1);
    chk("R5 marker one cycle", {31'h0, pm_irq[7]}, 32'h0);
    // R4 edge and clearing write in the same cycle
    chan_in = 8'h00; step(3);
    wr(2'd2, ident_cond | 32'h7F); step(2);
    chan_in = 8'h02; step(1);
    wr(2'd2, ident_cond | 32'h7F);
    chk("R4 edge seen in clear cycle", {31'h0, pm_irq[1]}, 32'h1);
    step(1);
    chk("R4 clear wins afterwards", {31'h0, pm_irq[1]}, 32'h0);

    // R6 chaining with endpoint at slice 2 only
    wr(2'd2, all_code(4) | 32'h04);
    chan_in = 8'h07; step(2);
    chk("R6 first term", {24'h0, pm_irq}, 32'h04);
    chan_in = 8'hF8; step(2);
    chk("R6 last term", {24'h0, pm_irq}, 32'h80);
    chan_in = 8'h03; step(2);
    chk("R6 partial term", {24'h0, pm_irq}, 32'h00);

    // R8 event
    chan_in = 8'h00; step(3);
    chan_in = 8'h07; step(2);
    chk("R8 event pulse", {31'h0, pm_event}, 32'h1);
    step(1);
    chk("R8 event one cycle", {31'h0, pm_event}, 32'h0);
    chan_in = 8'h00; step(2);
    wr(2'd0, 32'h1); step(1);
    chan_in = 8'h07; step(2);
    chk("R8 event disabled", {31'h0, pm_event}, 32'h0);
    chk("R8 irq still raised", {24'h0, pm_irq}, 32'h04);

    // R7 mode off, R9 readback
    wr(2'd0, 32'h0); step(2);
    chk("R7 irq off", {24'h0, pm_irq}, 32'h0);
    chk("R9 live match", {24'h0, match_state}, 32'h07);
    chk("R9 ctrl readback", ctrl_rdata, 32'h0700_0000);
    chan_in = 8'h00; step(2);
    chan_in = 8'h07; step(2);
    chk("R7 event off", {31'h0, pm_event}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule